// File: doc/BRIEF.md
# Census Stereo Matching Cost

This block turns a rectified pair of 8-bit raster streams into per-pixel stereo matching costs. Both streams enter together, one pixel per side per accepted cycle, row by row from the top-left corner. For each side, six row memories plus the incoming row supply a 7x7 neighbourhood. Each of the 48 neighbours is compared with the centre pixel, which gives a 48-bit signature. The left signature is then XORed against the right signatures of `NDISP` disparity candidates, and the set bits are counted. All candidate costs appear together in one output word.

A raster tracker follows the frame. It has three states: `ST_WAIT_SOF` (idle, waiting for a frame start), `ST_PRIME` (filling the first six rows, no window complete) and `ST_STREAM` (windows complete). It makes these transitions:
- `ST_WAIT_SOF` goes to `ST_PRIME` when a pixel with frame start is accepted.
- `ST_PRIME` goes to `ST_STREAM` when the first pixel of row 6 is accepted.
- `ST_PRIME` or `ST_STREAM` goes back to `ST_PRIME` when a new frame start is accepted.
- `ST_STREAM` goes to `ST_WAIT_SOF` when the last pixel of the frame (row `IMG_H-1`, column `IMG_W-1`) is accepted.

Costs are produced only for centres whose whole window lies inside the image. Downstream cost aggregation therefore never sees a padded window.

Top module: `census_cost`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is 0 and `out_cost` is all zeros until the first frame produces a result.
- R2: A pixel is taken only when `in_valid` is 1. While in `ST_WAIT_SOF`, pixels without `in_sof` are ignored and produce no output. A pixel with `in_sof` is column 0 of row 0. A pixel with `in_sol` is column 0 of the next row.
- R3: Signature bit for a neighbour is 1 exactly when that neighbour is strictly less than the window centre. All 48 non-centre positions of the 7x7 window contribute, so equal pixels give 0.
- R4: Each cost is the number of differing signature bits, in the range 0..48. Candidate d occupies `out_cost[6*d+5 : 6*d]`.
- R5: Candidate d compares the left signature centred at (row r, column c) with the right signature centred at (r, c-d).
- R6: A candidate whose right centre column c-d is below 3 (its window would leave the row at the left edge) outputs 48.
- R7: `out_valid` pulses once for each centre with 3 <= r <= IMG_H-4 and 3 <= c <= IMG_W-4, in raster order. That is exactly (IMG_H-6)*(IMG_W-6) results per frame.
- R8: The result for centre (r, c) appears on the third rising edge counted from the edge that accepts pixel (r+3, c+3). This is three rows plus three pixels plus two register stages.
- R9: Idle cycles (`in_valid` = 0) inside a frame change neither the values nor the order of results.
- R10: After the last pixel of a frame the tracker returns to `ST_WAIT_SOF`, and pixels without frame start are ignored until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel pair present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a row |
| in_left | input | PIX_W | Left image pixel |
| in_right | input | PIX_W | Right image pixel |
| out_valid | output | 1 | Cost vector valid |
| out_cost | output | NDISP*COST_W | Costs, candidate d at bits 6d+5..6d |

## Verification
The bench sweeps whole frames of a 12x9 image with four candidates, using random, shifted, flat, checkerboard and strictly ordered ramp images, and computes every cost from the pixel arrays. A ramp left image against its inverted right image forces the 48-cost extreme. A design that compared with less-or-equal, or included the centre, would give a different count. A wrong candidate shift would misplace the zero cost of the two-pixel shifted pair. Left-edge candidates must give 48; a design that reused signatures left over from the previous row would output a small cost there. Frames with idle gaps, stray pixels before a frame start and after the frame end, and the exact cycle of the first result catch designs that miscount rows or columns, emit results for partial windows, or add or drop a pipeline stage.

// File: rtl/census_pkg.sv
package census_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_SOF = 2'd0,
        ST_PRIME    = 2'd1,
        ST_STREAM   = 2'd2
    } raster_st_t;

    // number of set bits in a word of up to 64 bits
    function automatic int unsigned ones64(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/census_window.sv
module census_window #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 32,
    parameter int WIN   = 7,
    parameter int AW    = $clog2(IMG_W)
) (
    input  logic             clk,
    input  logic             push,
    input  logic [AW-1:0]    col,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] win_o [WIN][WIN]
);

    // row memories: row_mem[k][x] holds the pixel k+1 rows above the current one
    logic [PIX_W-1:0] row_mem [WIN-1][IMG_W];
    logic [PIX_W-1:0] col_vec [WIN];

    assign col_vec[0] = pix_in;

    for (genvar k = 1; k < WIN; k++) begin : g_tap
        assign col_vec[k] = row_mem[k-1][col];
    end

    always_ff @(posedge clk) begin
        if (push) begin
            row_mem[0][col] <= pix_in;
            for (int k = 1; k < WIN - 1; k++) begin
                row_mem[k][col] <= row_mem[k-1][col];
            end
        end
    end

    // window: win_o[r][j] = pixel r rows up and j columns left of the newest one
    always_ff @(posedge clk) begin
        if (push) begin
            for (int r = 0; r < WIN; r++) begin
                win_o[r][0] <= col_vec[r];
                for (int j = 1; j < WIN; j++) begin
                    win_o[r][j] <= win_o[r][j-1];
                end
            end
        end
    end

endmodule

// File: rtl/census_sig.sv
module census_sig #(
    parameter int PIX_W = 8,
    parameter int WIN   = 7,
    parameter int SIG_W = WIN * WIN - 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic [PIX_W-1:0] win [WIN][WIN],
    output logic [SIG_W-1:0] sig_q
);

    localparam int HALF = WIN / 2;
    localparam int CN   = HALF * WIN + HALF;

    logic [SIG_W-1:0] sig_c;

    for (genvar gr = 0; gr < WIN; gr++) begin : g_row
        for (genvar gj = 0; gj < WIN; gj++) begin : g_col
            if (gr * WIN + gj != CN) begin : g_bit
                localparam int IDX = (gr * WIN + gj < CN) ? gr * WIN + gj : gr * WIN + gj - 1;
                assign sig_c[IDX] = win[gr][gj] < win[HALF][HALF];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            sig_q <= sig_c;
        end
    end

endmodule

// File: rtl/census_side.sv
module census_side #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 32,
    parameter int WIN   = 7,
    parameter int AW    = $clog2(IMG_W),
    parameter int SIG_W = WIN * WIN - 1
) (
    input  logic             clk,
    input  logic             push,
    input  logic [AW-1:0]    col,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             sig_en,
    output logic [SIG_W-1:0] sig_q
);

    logic [PIX_W-1:0] win [WIN][WIN];

    census_window #(
        .PIX_W(PIX_W), .IMG_W(IMG_W), .WIN(WIN), .AW(AW)
    ) u_win (
        .clk   (clk),
        .push  (push),
        .col   (col),
        .pix_in(pix_in),
        .win_o (win)
    );

    census_sig #(
        .PIX_W(PIX_W), .WIN(WIN), .SIG_W(SIG_W)
    ) u_sig (
        .clk  (clk),
        .en   (sig_en),
        .win  (win),
        .sig_q(sig_q)
    );

endmodule

// File: rtl/hamming_cost.sv
module hamming_cost #(
    parameter int WIN    = 7,
    parameter int SIG_W  = WIN * WIN - 1,
    parameter int COST_W = $clog2(SIG_W + 1),
    parameter int NDISP  = 8,
    parameter int CW     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [CW-1:0]           col_i,
    input  logic [SIG_W-1:0]        sig_l,
    input  logic [SIG_W-1:0]        sig_r,
    output logic [NDISP*COST_W-1:0] cost_o,
    output logic                    vld_o
);

    // hist[d] = right signature d results back within the row
    logic [SIG_W-1:0]  hist   [NDISP];
    logic [COST_W-1:0] cost_q [NDISP];

    assign hist[0] = sig_r;

    for (genvar k = 1; k < NDISP; k++) begin : g_hist
        always_ff @(posedge clk) begin
            if (vld_i) begin
                hist[k] <= hist[k-1];
            end
        end
    end

    for (genvar d = 0; d < NDISP; d++) begin : g_cand
        // window newest column must reach WIN-1+d for the right window to be in the row
        localparam logic [CW-1:0] COL_MIN = CW'(WIN - 1 + d);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cost_q[d] <= '0;
            end else if (vld_i) begin
                if (col_i >= COL_MIN) begin
                    cost_q[d] <= COST_W'(census_pkg::ones64(64'(sig_l ^ hist[d])));
                end else begin
                    cost_q[d] <= COST_W'(SIG_W);
                end
            end
        end

        assign cost_o[d*COST_W +: COST_W] = cost_q[d];

        // R4
        cost_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o |-> (cost_q[d] <= COST_W'(SIG_W)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

endmodule

// File: rtl/census_cost.sv
module census_cost #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 32,
    parameter int IMG_H = 24,
    parameter int NDISP = 8,
    parameter int WIN   = 7,
    localparam int SIG_W  = WIN * WIN - 1,
    localparam int COST_W = $clog2(SIG_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_sol,
    input  logic [PIX_W-1:0]        in_left,
    input  logic [PIX_W-1:0]        in_right,
    output logic                    out_valid,
    output logic [NDISP*COST_W-1:0] out_cost
);
    import census_pkg::*;

    localparam int CW = $clog2(IMG_W + 1);
    localparam int AW = $clog2(IMG_W);
    localparam int RW = $clog2(IMG_H + 1);
    localparam logic [CW-1:0] COL_FULL = CW'(WIN - 1);
    localparam logic [RW-1:0] ROW_FULL = RW'(WIN - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
    localparam logic [CW-1:0] COL_LIM  = CW'(IMG_W);

    raster_st_t st_q, st_d;
    logic [CW-1:0] col_q, cur_col;
    logic [RW-1:0] row_q, cur_row;
    logic          acc, last_px;

    // position of the pixel presented this cycle
    always_comb begin
        cur_col = (in_sof || in_sol) ? '0 : col_q;
        if (in_sof) begin
            cur_row = '0;
        end else if (in_sol) begin
            cur_row = row_q + 1'b1;
        end else begin
            cur_row = row_q;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT_SOF: begin
                if (acc) st_d = ST_PRIME;
            end
            ST_PRIME: begin
                if (acc && !in_sof && cur_row == ROW_FULL) st_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (acc && in_sof) begin
                    st_d = ST_PRIME;
                end else if (acc && last_px) begin
                    st_d = ST_WAIT_SOF;
                end
            end
            default: st_d = ST_WAIT_SOF;
        endcase
    end

    // state register and raster counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT_SOF;
            col_q <= '0;
            row_q <= '0;
        end else begin
            st_q <= st_d;
            if (acc) begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
        end
    end

    // outputs of the tracker
    always_comb begin
        acc     = in_valid && (cur_col < COL_LIM) && ((st_q != ST_WAIT_SOF) || in_sof);
        last_px = (cur_row == ROW_LAST) && (cur_col == COL_LAST);
    end

    // stage 1: windows updated
    logic          w_vld_q, w_rowok_q;
    logic [CW-1:0] w_col_q;
    // stage 2: signatures registered
    logic          s_en, s_vld_q;
    logic [CW-1:0] s_col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_vld_q   <= 1'b0;
            w_rowok_q <= 1'b0;
            w_col_q   <= '0;
            s_vld_q   <= 1'b0;
            s_col_q   <= '0;
        end else begin
            w_vld_q <= acc;
            if (acc) begin
                w_rowok_q <= cur_row >= ROW_FULL;
                w_col_q   <= cur_col;
            end
            s_vld_q <= s_en;
            if (s_en) begin
                s_col_q <= w_col_q;
            end
        end
    end

    assign s_en = w_vld_q && w_rowok_q && (w_col_q >= COL_FULL);

    logic [PIX_W-1:0] side_pix [2];
    logic [SIG_W-1:0] side_sig [2];

    assign side_pix[0] = in_left;
    assign side_pix[1] = in_right;

    for (genvar s = 0; s < 2; s++) begin : g_side
        census_side #(
            .PIX_W(PIX_W), .IMG_W(IMG_W), .WIN(WIN), .AW(AW), .SIG_W(SIG_W)
        ) u_side (
            .clk   (clk),
            .push  (acc),
            .col   (cur_col[AW-1:0]),
            .pix_in(side_pix[s]),
            .sig_en(s_en),
            .sig_q (side_sig[s])
        );
    end

    hamming_cost #(
        .WIN(WIN), .SIG_W(SIG_W), .COST_W(COST_W), .NDISP(NDISP), .CW(CW)
    ) u_cost (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s_vld_q),
        .col_i (s_col_q),
        .sig_l (side_sig[0]),
        .sig_r (side_sig[1]),
        .cost_o(out_cost),
        .vld_o (out_valid)
    );

    // R10
    stream_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM) |-> (row_q >= ROW_FULL));

    // R2
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_SOF && !(in_valid && in_sof)) |=> !w_vld_q);

    // R8
    pipe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s_vld_q));

    // R7
    full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_vld_q |-> (s_col_q >= COL_FULL && s_col_q <= COL_LAST));

endmodule

// File: tb/tb_census_cost.sv
`timescale 1ns/1ps
module tb_census_cost;

    localparam int W  = 12;
    localparam int H  = 9;
    localparam int ND = 4;
    localparam int CB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [7:0] in_left = '0, in_right = '0;
    logic out_valid;
    logic [ND*CB-1:0] out_cost;

    census_cost #(
        .PIX_W(8), .IMG_W(W), .IMG_H(H), .NDISP(ND), .WIN(7)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_cost(out_cost)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    int Lp [H][W];
    int Rp [H][W];
    int exp_c [64][ND];
    int exp_n = 0, got_n = 0;
    int first_cyc = -1, want_cyc = 0;
    string tag = "R4";
    int unsigned seed = 32'h1234_5678;
    bit done = 0;

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int cost_of(input int r, input int c, input int d);
        int n;
        if (c - d < 3) return 48;
        n = 0;
        for (int dr = -3; dr <= 3; dr++) begin
            for (int dc = -3; dc <= 3; dc++) begin
                if (dr != 0 || dc != 0) begin
                    bit bl, br;
                    bl = Lp[r+dr][c+dc] < Lp[r][c];
                    br = Rp[r+dr][c-d+dc] < Rp[r][c-d];
                    if (bl != br) n++;
                end
            end
        end
        return n;
    endfunction

    task automatic prepare(input int pat);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                case (pat)
                    0: begin Lp[r][c] = int'(rnd() % 256); Rp[r][c] = int'(rnd() % 256); end
                    1: Lp[r][c] = int'(rnd() % 256);
                    2: begin Lp[r][c] = 77; Rp[r][c] = int'(rnd() % 256); end
                    3: begin Lp[r][c] = ((r + c) % 2 == 1) ? 255 : 0; Rp[r][c] = 255 - Lp[r][c]; end
                    default: begin Lp[r][c] = r * 5 + c * 3; Rp[r][c] = 255 - Lp[r][c]; end
                endcase
            end
        end
        if (pat == 1) begin
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    Rp[r][c] = (c + 2 < W) ? Lp[r][c+2] : int'(rnd() % 256);
                end
            end
        end
        exp_n = 0;
        for (int r = 3; r <= H - 4; r++) begin
            for (int c = 3; c <= W - 4; c++) begin
                for (int d = 0; d < ND; d++) exp_c[exp_n][d] = cost_of(r, c, d);
                exp_n++;
            end
        end
        got_n = 0;
        first_cyc = -1;
    endtask

    // monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (got_n == 0) first_cyc = cyc;
            if (got_n < exp_n) begin
                for (int d = 0; d < ND; d++) begin
                    int a;
                    int ce;
                    ce = 3 + (got_n % (W - 6));
                    a = int'(out_cost[d*CB +: CB]);
                    chk(a == exp_c[got_n][d], (ce - d < 3) ? "R6" : tag, a, exp_c[got_n][d]);
                end
            end else begin
                chk(1'b0, "R7", got_n + 1, exp_n);
            end
            got_n++;
        end
    end

    task automatic run_frame(input bit gaps);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps && (rnd() % 3 == 0)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_sol   = (c == 0);
                in_left  = 8'(Lp[r][c]);
                in_right = 8'(Rp[r][c]);
                if (r == 6 && c == 6) want_cyc = cyc + 3;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        repeat (6) @(negedge clk);
        // R7 one result per full window
        chk(got_n == exp_n, "R7", got_n, exp_n);
        // R8 first result timing
        if (!gaps) chk(first_cyc == want_cyc, "R8", first_cyc, want_cyc);
    endtask

    task automatic stray(input string req);
        exp_n = 0; got_n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = 1'b0;
            in_sol   = (i % W == 0);
            in_left  = 8'(rnd());
            in_right = 8'(rnd());
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        repeat (6) @(negedge clk);
        chk(got_n == 0, req, got_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 after reset
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_cost == '0, "R1", int'(out_cost), 0);

        stray("R2");
        tag = "R4"; prepare(0); run_frame(1'b0);
        stray("R10");
        tag = "R5"; prepare(1); run_frame(1'b1);
        tag = "R3"; prepare(2); run_frame(1'b0);
        tag = "R9"; prepare(3); run_frame(1'b1);
        tag = "R3"; prepare(4); run_frame(1'b0);
        tag = "R9"; prepare(0); run_frame(1'b1);
        stray("R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 50000 && !done) begin
            done = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

endmodule